// File: doc/BRIEF.md
# Mailbox Command Request Controller

This block sits on a host's memory-mapped bus and splits the host's address space into four data windows and one control window. Accesses that fall in a data window go straight out on a forwarding port, and they keep doing so whether or not a command is in progress. Accesses to the control window reach a small register file: a set of operand words, an opcode word, and a status word.

The host stores the operands and then writes the opcode. If the controller is idle, that opcode write captures a snapshot of the operands and starts a command on the execution-engine port. The engine reports completion with a one-cycle done pulse carrying an error flag and a result code. The controller then records the completion in status and raises its interrupt line. The host clears the interrupt either by reading status or by writing an acknowledge bit.

Top module: `mbox_cmd_ctrl`

## Requirements
- R1: After reset the status word reads 0, `irq` is low, `cmd_busy` is low and `cmd_start` is low.
- R2: The address window index is `host_addr[7:5]`. Index 4 is the control window. Within it, offsets 0, 1 and 2 hold the operand words, which the host can write and read back while the controller is idle.
- R3: A write to control offset 3 (opcode) while idle has these effects in the next cycle: `cmd_busy` is 1, `cmd_start` is 1 for exactly one cycle, `cmd_opcode` shows the written word, and `cmd_operands` shows the operands with operand 0 in the low 16 bits.
- R4: While busy, operand writes are ignored. Read-back and `cmd_operands` keep the values captured when the opcode was written.
- R5: An opcode write while busy does not change `cmd_opcode` and sets the overrun flag, which is status bit 12.
- R6: A done pulse while busy clears busy (status bit 15), sets done (bit 14) and raises `irq`. It also latches the engine error flag into bit 13 and the result code into bits 7:0, all in the next cycle.
- R7: Reading status (control offset 4) clears done and drops `irq` in the next cycle. If a completion lands in the same cycle as the read, done ends up set.
- R8: Writing status with bit 14 set clears done and drops `irq`. Writing status with bit 12 set clears overrun.
- R9: Control offsets above 4, and windows 5 to 7, read as zero and ignore writes.
- R10: An access to window 0 to 3 drives `dw_en`, `dw_wr`, `dw_win`, `dw_off` and `dw_wdata` in the same cycle, and returns `dw_rdata` on `host_rdata`. This holds while busy as well.
- R11: A done pulse while idle has no effect on status or `irq`.
- R12: Starting a command clears done, error and result. This drops `irq` if it was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access valid this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host address: window index in top 3 bits, offset below |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data (combinational) |
| irq | output | 1 | Completion interrupt, high while done is set |
| dw_en | output | 1 | Data-window access forwarded |
| dw_wr | output | 1 | Forwarded access is a write |
| dw_win | output | 2 | Data window number |
| dw_off | output | ADDR_W-3 | Offset within the data window |
| dw_wdata | output | DW | Forwarded write data |
| dw_rdata | input | DW | Read data returned for a data window |
| cmd_start | output | 1 | One-cycle start pulse to the engine |
| cmd_busy | output | 1 | Command in flight |
| cmd_opcode | output | DW | Latched opcode |
| cmd_operands | output | NUM_OPS*DW | Operand snapshot, operand 0 in the low word |
| eng_done | input | 1 | Engine completion pulse |
| eng_error | input | 1 | Engine error flag, valid with eng_done |
| eng_result | input | RES_W | Engine result code, valid with eng_done |

## Verification
The bench targets the ordering hazards around a pending command. It writes operands and opcodes while busy. A design that failed to freeze them would hand the engine a torn snapshot, or would restart an unfinished command instead of flagging overrun. It also places a status read in the same cycle as a completion. A design in which the clear beats the set would lose the interrupt entirely. Other checks cover a stray done pulse while idle, an acknowledge without a read, and data-window reads issued mid-command. These catch a design that latches spurious results, leaves `irq` stuck high, or stalls window traffic behind the command.

// File: rtl/mbox_cmd_ctrl.sv
module mbox_cmd_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int NUM_OPS = 3,
  parameter int DW      = 16,
  parameter int RES_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_sel,
  input  logic                  host_wr,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [DW-1:0]         host_wdata,
  output logic [DW-1:0]         host_rdata,
  output logic                  irq,
  output logic                  dw_en,
  output logic                  dw_wr,
  output logic [1:0]            dw_win,
  output logic [ADDR_W-4:0]     dw_off,
  output logic [DW-1:0]         dw_wdata,
  input  logic [DW-1:0]         dw_rdata,
  output logic                  cmd_start,
  output logic                  cmd_busy,
  output logic [DW-1:0]         cmd_opcode,
  output logic [NUM_OPS*DW-1:0] cmd_operands,
  input  logic                  eng_done,
  input  logic                  eng_error,
  input  logic [RES_W-1:0]      eng_result
);
  localparam int WIN_W = 3;
  localparam int OFF_W = ADDR_W - WIN_W;
  localparam logic [WIN_W-1:0] CTRL_WIN = WIN_W'(4);
  localparam logic [OFF_W-1:0] OFF_OPC = OFF_W'(NUM_OPS);
  localparam logic [OFF_W-1:0] OFF_STS = OFF_W'(NUM_OPS + 1);
  localparam int PAD_W = DW - 4 - RES_W;
  localparam int B_BUSY = DW - 1;
  localparam int B_DONE = DW - 2;
  localparam int B_OVR  = DW - 4;

  logic [WIN_W-1:0] win;
  logic [OFF_W-1:0] off;
  logic ctrl, wr_ctrl, rd_ctrl, opw, stw, str, start, fin;
  logic busy, done, err, ovr, start_q;
  logic [RES_W-1:0] result;
  logic [DW-1:0] opcode;
  logic [DW-1:0] ops [NUM_OPS];
  logic [DW-1:0] status;

  assign win     = host_addr[ADDR_W-1 -: WIN_W];
  assign off     = host_addr[OFF_W-1:0];
  assign ctrl    = host_sel && (win == CTRL_WIN);
  assign wr_ctrl = ctrl && host_wr;
  assign rd_ctrl = ctrl && !host_wr;
  assign opw     = wr_ctrl && (off == OFF_OPC);
  assign stw     = wr_ctrl && (off == OFF_STS);
  assign str     = rd_ctrl && (off == OFF_STS);
  assign start   = opw && !busy;
  assign fin     = eng_done && busy;

  assign dw_en    = host_sel && (win < CTRL_WIN);
  assign dw_wr    = host_wr;
  assign dw_win   = win[1:0];
  assign dw_off   = off;
  assign dw_wdata = host_wdata;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_OPS; gi++) begin : g_op
      always_ff @(posedge clk) begin
        if (!rst_n) ops[gi] <= '0;
        else if (wr_ctrl && (off == OFF_W'(gi)) && !busy) ops[gi] <= host_wdata;
      end
      assign cmd_operands[gi*DW +: DW] = ops[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      start_q <= 1'b0;
      opcode  <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      ovr     <= 1'b0;
      result  <= '0;
    end else begin
      start_q <= start;
      if (start) begin
        busy   <= 1'b1;
        opcode <= host_wdata;
        done   <= 1'b0;
        err    <= 1'b0;
        result <= '0;
      end else if (fin) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        err    <= eng_error;
        result <= eng_result;
      end else if (str || (stw && host_wdata[B_DONE])) begin
        done <= 1'b0;
      end
      if (opw && busy) ovr <= 1'b1;
      else if (stw && host_wdata[B_OVR]) ovr <= 1'b0;
    end
  end

  assign status     = {busy, done, err, ovr, {PAD_W{1'b0}}, result};
  assign irq        = done;
  assign cmd_start  = start_q;
  assign cmd_busy   = busy;
  assign cmd_opcode = opcode;

  always_comb begin
    host_rdata = '0;
    if (dw_en) host_rdata = dw_rdata;
    else if (rd_ctrl) begin
      for (int i = 0; i < NUM_OPS; i++)
        if (off == OFF_W'(i)) host_rdata = ops[i];
      if (off == OFF_OPC) host_rdata = opcode;
      if (off == OFF_STS) host_rdata = status;
    end
  end

  AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> cmd_busy); // R3
  AST_OPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && !eng_done) |=> $stable(cmd_operands) && $stable(cmd_opcode)); // R4
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (opw && cmd_busy) |=> status[B_OVR]); // R5
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && eng_done) |=> irq && !cmd_busy); // R6
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (str && !fin) |=> !irq); // R7
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_busy && !irq && !start) |=> !irq); // R11
  AST_DW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dw_en && ctrl)); // R10
endmodule

// File: tb/sim_mbox_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_mbox_cmd_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_sel = 0, host_wr = 0;
  logic [7:0] host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata, dw_wdata, cmd_opcode;
  logic [15:0] dw_rdata = 16'hD00D;
  logic irq, dw_en, dw_wr, cmd_start, cmd_busy;
  logic [1:0] dw_win;
  logic [4:0] dw_off;
  logic [47:0] cmd_operands;
  logic eng_done = 0, eng_error = 0;
  logic [7:0] eng_result = '0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mbox_cmd_ctrl u0 (.clk, .rst_n, .host_sel, .host_wr, .host_addr, .host_wdata,
    .host_rdata, .irq, .dw_en, .dw_wr, .dw_win, .dw_off, .dw_wdata, .dw_rdata,
    .cmd_start, .cmd_busy, .cmd_opcode, .cmd_operands, .eng_done, .eng_error,
    .eng_result);

  // {wr, addr, data, expected}
  localparam logic [40:0] VEC [10] = '{
    {1'b1, 8'h80, 16'h1111, 16'h0000},
    {1'b1, 8'h81, 16'h2222, 16'h0000},
    {1'b1, 8'h82, 16'h3333, 16'h0000},
    {1'b1, 8'hE0, 16'hFFFF, 16'h0000},
    {1'b1, 8'h85, 16'hFFFF, 16'h0000},
    {1'b0, 8'h80, 16'h0000, 16'h1111},
    {1'b0, 8'h81, 16'h0000, 16'h2222},
    {1'b0, 8'h82, 16'h0000, 16'h3333},
    {1'b0, 8'h85, 16'h0000, 16'h0000},
    {1'b0, 8'hE0, 16'h0000, 16'h0000}};

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_sel = 0; host_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 0; host_addr = a;
    #1 d = host_rdata;
    @(posedge clk); #1;
    host_sel = 0;
  endtask

  task automatic eng(logic e, logic [7:0] r);
    @(negedge clk);
    eng_done = 1; eng_error = e; eng_result = r;
    @(posedge clk); #1;
    eng_done = 0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 irq", irq, 0);
    chk("R1 busy", cmd_busy, 0);
    chk("R1 start", cmd_start, 0);
    rd(8'h84, d); chk("R1 status", d, 16'h0000);

    foreach (VEC[i]) begin
      if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:16]);
      else begin
        rd(VEC[i][39:32], d);
        chk("R2/R9 vector", d, VEC[i][15:0]);
      end
    end

    // R10 idle forwarding
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = 8'h25; host_wdata = 16'hCAFE;
    #1;
    chk("R10 en", dw_en, 1); chk("R10 wr", dw_wr, 1);
    chk("R10 win", dw_win, 1); chk("R10 off", dw_off, 5);
    chk("R10 wdata", dw_wdata, 16'hCAFE);
    @(posedge clk); #1 host_sel = 0; host_wr = 0;

    // R3 start
    wr(8'h83, 16'h00A5);
    chk("R3 start", cmd_start, 1);
    chk("R3 busy", cmd_busy, 1);
    chk("R3 opcode", cmd_opcode, 16'h00A5);
    chk("R3 operands", cmd_operands, 48'h3333_2222_1111);
    @(posedge clk); #1;
    chk("R3 start one cycle", cmd_start, 0);

    // R4 frozen operands
    wr(8'h80, 16'hBEEF);
    rd(8'h80, d); chk("R4 readback", d, 16'h1111);
    chk("R4 snapshot", cmd_operands, 48'h3333_2222_1111);

    // R5 overrun
    wr(8'h83, 16'h0077);
    chk("R5 opcode kept", cmd_opcode, 16'h00A5);
    rd(8'h84, d); chk("R5 status", d, 16'h9000);

    // R10 while busy
    dw_rdata = 16'h4242;
    rd(8'h61, d); chk("R10 busy read", d, 16'h4242);

    // R6 completion with error
    eng(1, 8'h3C);
    chk("R6 irq", irq, 1); chk("R6 busy", cmd_busy, 0);
    rd(8'h84, d); chk("R6 status", d, 16'h703C);
    chk("R7 irq after read", irq, 0);

    // R8 clear overrun
    wr(8'h84, 16'h1000);
    rd(8'h84, d); chk("R8 overrun cleared", d, 16'h203C);

    // R11 stray done
    eng(0, 8'hEE);
    chk("R11 irq", irq, 0);
    rd(8'h84, d); chk("R11 status", d, 16'h203C);

    // R12 start clears
    wr(8'h83, 16'h0011);
    rd(8'h84, d); chk("R12 status", d, 16'h8000);
    eng(0, 8'h5A);
    chk("R6 irq again", irq, 1);
    wr(8'h84, 16'h4000);
    chk("R8 ack irq", irq, 0);
    rd(8'h84, d); chk("R8 status", d, 16'h005A);

    // R7 read coincident with completion
    wr(8'h83, 16'h0022);
    @(negedge clk);
    host_sel = 1; host_wr = 0; host_addr = 8'h84;
    eng_done = 1; eng_error = 0; eng_result = 8'h66;
    #1 d = host_rdata;
    @(posedge clk); #1;
    host_sel = 0; eng_done = 0;
    chk("R7 coincident read value", d, 16'h8000);
    chk("R7 coincident irq", irq, 1);

    // R12 start drops irq
    wr(8'h83, 16'h0033);
    chk("R12 irq dropped", irq, 0);
    eng(0, 8'h01);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule